// File: doc/BRIEF.md
# Tile Coverage Hit Buffer with Path-Ordered Readout

This block holds the pixel coverage of one screen tile, one coverage word at a time, and hands it downstream in a fixed traversal order. An upstream coverage evaluator writes a whole 16-bit group word per clock through an address/data/write-enable port. Each word describes a 4x4 pixel group as four 2x2 quads of four pixel bits. Four groups form a block, and eight blocks make up the tile.

A consumer raises a read request whenever it can accept work. In response the buffer locates the earliest quad along the traversal path that still has a covered pixel. It reports that quad's block, group and quad index together with its 4-bit pixel mask, and erases those pixel bits in the same step, so no pixel is delivered twice. The search is hierarchical: first the block, then the group inside that block, then the quad inside that group. A level flag tells the consumer when nothing is left to deliver. The blocks are taken in index order, and inside a block the groups and quads are each taken in 2x2 Z-order.

Top module: `hitbuf_top`

## Requirements
- R1: After reset every coverage bit is zero, `rspValid` is low and `allDrained` is high.
- R2: A write with `wrEn` high stores `wrData` in word `wrAddr`, where the address is `block*4 + group`. Bit `4*q + p` of a word is pixel `p` of quad `q`.
- R3: A read request sampled at a clock edge with at least one covered pixel in the buffer gives, after that edge, `rspValid` high and a non-zero `rspMask` equal to the stored pixel bits of the selected quad.
- R4: The selected quad is the one with the lowest word address that holds any covered pixel, and inside that word the lowest quad index with a covered pixel. `rspBlock` is the upper three address bits, `rspGroup` the lower two bits and `rspQuad` the quad index.
- R5: The pixel bits of a quad that has been delivered are cleared in the same edge, so the next request moves on to the next quad on the path.
- R6: A read request while the buffer is empty gives `rspValid` low, with `rspMask`, `rspBlock`, `rspGroup` and `rspQuad` all zero.
- R7: `allDrained` is high exactly when no coverage bit is set in the stored contents, and it follows them in the cycle after each edge.
- R8: When a write and a read happen at the same edge, the read selects from the contents held before that edge. If the write targets the word being read, it stores `wrData` with the delivered quad's four bits forced to zero. A write to any other word is stored unchanged.
- R9: In a cycle after an edge with no read request, `rspValid` is low and all response fields are zero.
- R10: A write replaces the whole word rather than merging with it, so writing zero removes every pending pixel in that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Store `wrData` into word `wrAddr` |
| wrAddr | input | 5 | Word address, block*4 + group |
| wrData | input | 16 | Coverage of one group, 4 bits per quad |
| rdReq | input | 1 | Request the next covered quad |
| rspValid | output | 1 | Response fields hold a delivered quad |
| rspBlock | output | 3 | Block index of the delivered quad |
| rspGroup | output | 2 | Group index inside the block |
| rspQuad | output | 2 | Quad index inside the group |
| rspMask | output | 4 | Covered pixels of the delivered quad |
| allDrained | output | 1 | No covered pixel remains in the buffer |

## Verification
A wrong priority decision shows up at the ports in the very next response, as an out-of-order block, group or quad index. A failed clear shows up on the following request, as the same quad delivered again, and can keep `allDrained` low after the path is exhausted. A bad merge of a same-edge write and clear appears a few requests later as a missing or resurrected quad. The bench replays every cycle against a behavioural model of the word store, so each of these faults is caught in the cycle where it first becomes visible.

// File: rtl/hitbuf_pkg.sv
package hitbuf_pkg;

  parameter int NUM_BLOCKS       = 8;
  parameter int GROUPS_PER_BLOCK = 4;
  parameter int QUADS_PER_GROUP  = 4;
  parameter int PIX_PER_QUAD     = 4;

  localparam int BLK_W     = $clog2(NUM_BLOCKS);
  localparam int GRP_W     = $clog2(GROUPS_PER_BLOCK);
  localparam int QUAD_W    = $clog2(QUADS_PER_GROUP);
  localparam int WORD_BITS = QUADS_PER_GROUP * PIX_PER_QUAD;
  localparam int NUM_WORDS = NUM_BLOCKS * GROUPS_PER_BLOCK;
  localparam int ADDR_W    = BLK_W + GRP_W;

  // Strobes from the selector to the storage datapath
  typedef struct packed {
    logic              clr;   // deliver and erase one quad this edge
    logic [ADDR_W-1:0] word;  // word holding that quad
    logic [QUAD_W-1:0] quad;  // quad index inside the word
  } clrStrobe_t;

  // Index of the lowest set bit, zero when none is set
  function automatic int unsigned lowestSet(input logic [63:0] vec);
    int unsigned idx;
    idx = 0;
    for (int i = 63; i >= 0; i--) begin
      if (vec[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/hitbuf_ctrl.sv
module hitbuf_ctrl
  import hitbuf_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rdReq,
  input  logic [NUM_WORDS-1:0]       wordHit,
  input  logic [QUADS_PER_GROUP-1:0] quadHit,
  output logic [ADDR_W-1:0]          selWord,
  output clrStrobe_t                 strobe
);

  logic [NUM_BLOCKS-1:0]       blockHit;
  logic [GROUPS_PER_BLOCK-1:0] groupHit;
  logic [BLK_W-1:0]            blkIdx;
  logic [GRP_W-1:0]            grpIdx;
  logic [QUAD_W-1:0]           quadIdx;

  // Level 1: one summary bit per block
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blockOr
    assign blockHit[b] = |wordHit[b*GROUPS_PER_BLOCK +: GROUPS_PER_BLOCK];
  end

  always_comb begin
    blkIdx   = BLK_W'(lowestSet(64'(blockHit)));
    // Level 2: groups of the winning block
    groupHit = wordHit[blkIdx*GROUPS_PER_BLOCK +: GROUPS_PER_BLOCK];
    grpIdx   = GRP_W'(lowestSet(64'(groupHit)));
    selWord  = {blkIdx, grpIdx};
    // Level 3: quads of the winning group
    quadIdx  = QUAD_W'(lowestSet(64'(quadHit)));

    strobe.clr  = rdReq && (|blockHit);
    strobe.word = selWord;
    strobe.quad = quadIdx;
  end

  AST_CLEAR_HITS_LIVE_QUAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |-> (wordHit[strobe.word] && quadHit[strobe.quad])) else $error("clear of empty quad"); // R4

  AST_NO_EARLIER_WORD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |-> ((wordHit & ((NUM_WORDS'(1) << strobe.word) - NUM_WORDS'(1))) == '0)) else $error("earlier word skipped"); // R4

endmodule

// File: rtl/hitbuf_dp.sv
module hitbuf_dp
  import hitbuf_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [WORD_BITS-1:0]       wrData,
  input  clrStrobe_t                 strobe,
  input  logic [ADDR_W-1:0]          selWord,
  output logic [NUM_WORDS-1:0]       wordHit,
  output logic [QUADS_PER_GROUP-1:0] quadHit,
  output logic                       rspValid,
  output logic [BLK_W-1:0]           rspBlock,
  output logic [GRP_W-1:0]           rspGroup,
  output logic [QUAD_W-1:0]          rspQuad,
  output logic [PIX_PER_QUAD-1:0]    rspMask,
  output logic                       allDrained
);

  logic [NUM_WORDS-1:0][WORD_BITS-1:0] mem;
  logic [NUM_WORDS-1:0][WORD_BITS-1:0] memNext;
  logic [WORD_BITS-1:0]                selData;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_wordOr
    assign wordHit[w] = |mem[w];
  end

  assign selData = mem[selWord];

  for (genvar q = 0; q < QUADS_PER_GROUP; q++) begin : g_quadOr
    assign quadHit[q] = |selData[q*PIX_PER_QUAD +: PIX_PER_QUAD];
  end

  assign allDrained = ~|wordHit;

  // Write lands first, then the delivered quad is erased on top of it
  always_comb begin
    memNext = mem;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wrEn && (wrAddr == ADDR_W'(w))) memNext[w] = wrData;
      if (strobe.clr && (strobe.word == ADDR_W'(w)))
        memNext[w][strobe.quad*PIX_PER_QUAD +: PIX_PER_QUAD] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mem <= '0;
    else       mem <= memNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspBlock <= '0;
      rspGroup <= '0;
      rspQuad  <= '0;
      rspMask  <= '0;
    end else if (strobe.clr) begin
      rspValid <= 1'b1;
      rspBlock <= strobe.word[ADDR_W-1 -: BLK_W];
      rspGroup <= strobe.word[GRP_W-1:0];
      rspQuad  <= strobe.quad;
      rspMask  <= mem[strobe.word][strobe.quad*PIX_PER_QUAD +: PIX_PER_QUAD];
    end else begin
      rspValid <= 1'b0;
      rspBlock <= '0;
      rspGroup <= '0;
      rspQuad  <= '0;
      rspMask  <= '0;
    end
  end

  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspMask != '0)) else $error("empty mask delivered"); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspMask == '0 && rspQuad == '0 && rspGroup == '0 && rspBlock == '0)) else $error("idle fields not zero"); // R9

  AST_DELIVERED_ERASED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (mem[$past(strobe.word)][$past(strobe.quad)*PIX_PER_QUAD +: PIX_PER_QUAD] == '0)) else $error("quad survived delivery"); // R5

endmodule

// File: rtl/hitbuf_top.sv
module hitbuf_top
  import hitbuf_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [WORD_BITS-1:0]    wrData,
  input  logic                    rdReq,
  output logic                    rspValid,
  output logic [BLK_W-1:0]        rspBlock,
  output logic [GRP_W-1:0]        rspGroup,
  output logic [QUAD_W-1:0]       rspQuad,
  output logic [PIX_PER_QUAD-1:0] rspMask,
  output logic                    allDrained
);

  logic [NUM_WORDS-1:0]       wordHit;
  logic [QUADS_PER_GROUP-1:0] quadHit;
  logic [ADDR_W-1:0]          selWord;
  clrStrobe_t                 strobe;

  hitbuf_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .rdReq   (rdReq),
    .wordHit (wordHit),
    .quadHit (quadHit),
    .selWord (selWord),
    .strobe  (strobe)
  );

  hitbuf_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .strobe     (strobe),
    .selWord    (selWord),
    .wordHit    (wordHit),
    .quadHit    (quadHit),
    .rspValid   (rspValid),
    .rspBlock   (rspBlock),
    .rspGroup   (rspGroup),
    .rspQuad    (rspQuad),
    .rspMask    (rspMask),
    .allDrained (allDrained)
  );

  AST_RESP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(rdReq)) else $error("response without request"); // R3

  AST_DRAINED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && allDrained) |=> !rspValid) else $error("response from empty buffer"); // R6

endmodule

// File: tb/hitbuf_top_tb_top.sv
module hitbuf_top_tb_top;
  import hitbuf_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    wrEn = 1'b0;
  logic [ADDR_W-1:0]       wrAddr = '0;
  logic [WORD_BITS-1:0]    wrData = '0;
  logic                    rdReq = 1'b0;
  logic                    rspValid;
  logic [BLK_W-1:0]        rspBlock;
  logic [GRP_W-1:0]        rspGroup;
  logic [QUAD_W-1:0]       rspQuad;
  logic [PIX_PER_QUAD-1:0] rspMask;
  logic                    allDrained;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  hitbuf_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdReq(rdReq), .rspValid(rspValid), .rspBlock(rspBlock), .rspGroup(rspGroup),
    .rspQuad(rspQuad), .rspMask(rspMask), .allDrained(allDrained)
  );

  // Bundle layout: valid, block(3), group(2), quad(2), mask(4), drained
  function automatic logic [12:0] actualBundle();
    return {rspValid, rspBlock, rspGroup, rspQuad, rspMask, allDrained};
  endfunction

  function automatic bit modelEmpty();
    for (int i = 0; i < 32; i++) if (model[i] != 16'h0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic compare(input string tag, input logic [12:0] exp);
    logic [12:0] act;
    act = actualBundle();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %013b expected %013b (v,blk,grp,quad,mask,drained)", tag, act, exp);
    end
  endtask

  // One clock: inputs applied at a falling edge, result checked at the next one
  task automatic step(input bit we, input int addr, input logic [15:0] data,
                      input bit rd, input string tag);
    logic [12:0] exp;
    int hitW, hitQ;
    logic [3:0] m;
    wrEn = we; wrAddr = ADDR_W'(addr); wrData = data; rdReq = rd;
    hitW = -1; hitQ = 0; m = 4'h0;
    if (rd) begin
      for (int w = 0; w < 32 && hitW < 0; w++) begin
        for (int q = 0; q < 4 && hitW < 0; q++) begin
          if (model[w][4*q +: 4] != 4'h0) begin
            hitW = w; hitQ = q; m = model[w][4*q +: 4];
          end
        end
      end
    end
    if (we) model[addr] = data;
    if (hitW >= 0) model[hitW][4*hitQ +: 4] = 4'h0;
    if (hitW >= 0)
      exp = {1'b1, 3'(hitW >> 2), 2'(hitW & 3), 2'(hitQ), m, 1'b0};
    else
      exp = 13'h0;
    exp[0] = modelEmpty();
    @(negedge clk);
    compare(tag, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int guard;
    for (int i = 0; i < 32; i++) model[i] = 16'h0;
    repeat (3) @(negedge clk);
    compare("R1 during reset", 13'b0_000_00_00_0000_1);
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after reset", 13'b0_000_00_00_0000_1);

    step(0, 0, 16'h0, 1, "R6 empty read");

    // R2 / R4 / R5: word 9 (block 2 group 1) quads 1 and 2, word 2 quad 3
    step(1, 9, 16'h0F30, 0, "R2 write word 9");
    step(1, 2, 16'h8000, 0, "R2 write word 2");
    step(0, 0, 16'h0, 1, "R4 earliest word first");
    step(0, 0, 16'h0, 0, "R9 idle cycle");
    step(0, 0, 16'h0, 1, "R4 quad 1 of word 9");
    step(0, 0, 16'h0, 1, "R5 next quad after clear");
    step(0, 0, 16'h0, 1, "R6 read after drain");
    step(0, 0, 16'h0, 0, "R7 drained level");

    // R10: whole-word replace
    step(1, 5, 16'hFFFF, 0, "R10 fill word 5");
    step(1, 5, 16'h0000, 0, "R10 zero word 5");
    step(0, 0, 16'h0, 1, "R10 nothing left");

    // R8: write and read on the same word in one edge
    step(1, 0, 16'h0011, 0, "R2 write word 0");
    step(1, 0, 16'h1111, 1, "R8 same word write and read");
    step(1, 31, 16'h2000, 1, "R8 other word write and read");
    step(0, 0, 16'h0, 1, "R8 quad 2 remains");
    step(0, 0, 16'h0, 1, "R8 quad 3 remains");
    step(0, 0, 16'h0, 1, "R8 far word delivered");
    step(0, 0, 16'h0, 1, "R6 empty again");

    // R4 bulk: fill every word, drain along the whole path
    for (int i = 0; i < 32; i++)
      step(1, i, 16'((i * 16'h2B1D) ^ (i << 3) ^ 16'h0101), 0, "R2 bulk write");
    guard = 0;
    while (!modelEmpty() && guard < 200) begin
      step(0, 0, 16'h0, 1, "R4 bulk drain order");
      guard++;
    end
    step(0, 0, 16'h0, 1, "R7 bulk drained");

    // R3 mixed requests and R9 gaps
    step(1, 17, 16'h0A05, 1, "R3 write then read");
    step(0, 0, 16'h0, 1, "R3 first quad");
    step(0, 0, 16'h0, 0, "R9 gap");
    step(0, 0, 16'h0, 1, "R3 second quad");
    step(0, 0, 16'h0, 1, "R6 final empty");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule